// File: doc/BRIEF.md
# Cascaded Counter with Two-Phase Multiplexed Capture

The block chains two equal-width counter halves into one double-width counter. The lower half advances once for every rising edge of a count-enable strobe. The upper half advances in the same step in which the lower half rolls over from all ones to zero.

A one-cycle capture event snapshots the double-width count into two half-width registers over one shared half-width multiplexed path. The lower half is loaded into the sub register in the first transfer cycle. The upper half is loaded into the main register in the second. While the transfer runs, further capture events are dropped. A CPU read request of the main register is answered with a wait signal, and a read-enable output marks the cycles in which the main register may be read safely.

A count step whose edge falls in the first transfer cycle is held back by one cycle. The upper half therefore cannot move between the two loads, and the sub/main pair is always coherent. The step is applied one cycle late and is never lost.

Top module: `casc_capture_unit`

## Requirements
- R1: The lower half advances by one only in a cycle where cntEnable is sampled high after being sampled low in the previous cycle; holding cntEnable high for many cycles gives exactly one step.
- R2: The upper half advances by one exactly in the count step in which the lower half goes from all ones to zero (for 8-bit halves, 0x00FF steps to 0x0100), and at no other time.
- R3: A capEvent accepted in the idle phase loads the lower half into subCap at the end of the first cycle after the event, and the upper half into mainCap at the end of the second. The captured value is the count present in the first cycle after the event.
- R4: A capEvent that arrives while a transfer is in progress (the two cycles after an accepted event) is ignored and starts no further capture.
- R5: rdWait equals rdReq during the two transfer cycles and is 0 at all other times.
- R6: rdEnable is 0 during the two transfer cycles and 1 otherwise.
- R7: A count step whose rising edge falls in the first transfer cycle takes effect one cycle later, so mainCap holds the upper half that matches subCap. The step still reaches the counter.
- R8: While rst_n is low, both counter halves, subCap and mainCap are 0, rdEnable is 1 and rdWait is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cntEnable | input | 1 | Count-enable strobe; each rising edge is one count step |
| capEvent | input | 1 | Single-cycle capture event, already edge-selected |
| rdReq | input | 1 | CPU read request for the main capture register |
| subCap | output | HALF_W | Sub capture register (lower half of the snapshot) |
| mainCap | output | HALF_W | Main capture register (upper half of the snapshot) |
| rdWait | output | 1 | Stall for a main-register read during a transfer |
| rdEnable | output | 1 | High when the main register may be read safely |

## Verification
The bench builds the block with HALF_W set to 8. A lower-half rollover then costs only 256 count steps, so carries into the upper half, repeated carries and captures taken right at the rollover are all reached within a short run. The directed part lines up a capture event and a count edge in the exact transfer cycles. This covers the dropped event, the deferred count step around a rollover, and the read wait.

// File: rtl/cap_pkg.sv
package cap_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } capPhase_e;

  typedef struct packed {
    logic stepCount;
    logic selHigh;
    logic loadSub;
    logic loadMain;
  } capStrobes_t;

endpackage

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import cap_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cntEnable,
  input  logic        capEvent,
  input  logic        rdReq,
  output capStrobes_t strobes,
  output logic        rdWait,
  output logic        rdEnable
);

  capPhase_e phase, phaseNext;
  logic      enPrev;
  logic      pendStep;
  logic      riseEn;

  assign riseEn = cntEnable & ~enPrev;

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE: if (capEvent) phaseNext = PH_LOW;
      PH_LOW:  phaseNext = PH_HIGH;
      PH_HIGH: phaseNext = PH_IDLE;
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      enPrev   <= 1'b0;
      pendStep <= 1'b0;
    end else begin
      phase    <= phaseNext;
      enPrev   <= cntEnable;
      pendStep <= (phase == PH_LOW) && riseEn;
    end
  end

  // A step whose edge lands between the two loads waits one cycle
  always_comb begin
    strobes.stepCount = (riseEn && (phase != PH_LOW)) || pendStep;
    strobes.selHigh   = (phase == PH_HIGH);
    strobes.loadSub   = (phase == PH_LOW);
    strobes.loadMain  = (phase == PH_HIGH);
  end

  assign rdEnable = (phase == PH_IDLE);
  assign rdWait   = rdReq && (phase != PH_IDLE);

endmodule

// File: rtl/cnt_stage.sv
module cnt_stage #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stepIn,
  output logic [WIDTH-1:0] value
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      value <= '0;
    else if (stepIn) value <= value + 1'b1;
  end

endmodule

// File: rtl/cap_datapath.sv
module cap_datapath
  import cap_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  capStrobes_t       strobes,
  output logic [HALF_W-1:0] subCap,
  output logic [HALF_W-1:0] mainCap
);

  localparam int NUM_STAGES = 2;
  localparam logic [HALF_W-1:0] STAGE_MAX = {HALF_W{1'b1}};

  logic [NUM_STAGES-1:0] stepChain;
  logic [HALF_W-1:0]     stageVal [NUM_STAGES];
  logic [HALF_W-1:0]     muxBus;

  assign stepChain[0] = strobes.stepCount;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    cnt_stage #(.WIDTH(HALF_W)) u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .stepIn (stepChain[g]),
      .value  (stageVal[g])
    );
    if (g < NUM_STAGES - 1) begin : g_carry
      assign stepChain[g+1] = stepChain[g] && (stageVal[g] == STAGE_MAX);
    end
  end

  assign muxBus = strobes.selHigh ? stageVal[1] : stageVal[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      subCap  <= '0;
      mainCap <= '0;
    end else begin
      if (strobes.loadSub)  subCap  <= muxBus;
      if (strobes.loadMain) mainCap <= muxBus;
    end
  end

endmodule

// File: rtl/casc_capture_unit.sv
module casc_capture_unit
  import cap_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cntEnable,
  input  logic              capEvent,
  input  logic              rdReq,
  output logic [HALF_W-1:0] subCap,
  output logic [HALF_W-1:0] mainCap,
  output logic              rdWait,
  output logic              rdEnable
);

  capStrobes_t strobes;

  cap_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cntEnable (cntEnable),
    .capEvent  (capEvent),
    .rdReq     (rdReq),
    .strobes   (strobes),
    .rdWait    (rdWait),
    .rdEnable  (rdEnable)
  );

  cap_datapath #(.HALF_W(HALF_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .subCap  (subCap),
    .mainCap (mainCap)
  );

endmodule

// File: rtl/cap_checker.sv
module cap_checker #(
  parameter int HALF_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              capEvent,
  input logic              rdReq,
  input logic              rdWait,
  input logic              rdEnable,
  input logic [HALF_W-1:0] subCap,
  input logic [HALF_W-1:0] mainCap
);

  AST_EVENT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (capEvent && rdEnable) |=> !rdEnable); // R3

  AST_SUB_IN_TRANSFER: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(subCap) |-> !rdEnable); // R3

  AST_MAIN_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mainCap) |-> (rdEnable && $past(!rdEnable))); // R7

  AST_TRANSFER_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdEnable && $past(!rdEnable)) |=> rdEnable); // R4

  AST_WAIT_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rdWait |-> (rdReq && !rdEnable)); // R5

  AST_WAIT_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (rdReq && !rdEnable) |-> rdWait); // R5

  always_comb begin
    if (!rst_n) begin
      AST_RESET_IDLE: assert (rdEnable && !rdWait); // R8
    end
  end

endmodule

bind casc_capture_unit cap_checker #(.HALF_W(HALF_W)) u_cap_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .capEvent (capEvent),
  .rdReq    (rdReq),
  .rdWait   (rdWait),
  .rdEnable (rdEnable),
  .subCap   (subCap),
  .mainCap  (mainCap)
);

// File: tb/test_casc_capture_unit.sv
module test_casc_capture_unit;

  localparam int CLK_PERIOD = 10;
  localparam int HW = 8;
  localparam int VEC_N = 6;
  localparam int STEPS_TAB [VEC_N] = '{3, 252, 1, 255, 1, 7};
  localparam logic [2*HW-1:0] EXP_TAB [VEC_N] =
    '{16'h0003, 16'h00FF, 16'h0100, 16'h01FF, 16'h0200, 16'h0207};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cntEnable = 1'b0;
  logic capEvent = 1'b0;
  logic rdReq = 1'b0;
  logic [HW-1:0] subCap, mainCap;
  logic rdWait, rdEnable;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  casc_capture_unit #(.HALF_W(HW)) i_casc_capture_unit (
    .clk(clk), .rst_n(rst_n), .cntEnable(cntEnable), .capEvent(capEvent),
    .rdReq(rdReq), .subCap(subCap), .mainCap(mainCap),
    .rdWait(rdWait), .rdEnable(rdEnable)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic stepOnce();
    @(negedge clk) cntEnable = 1'b1;
    @(negedge clk) cntEnable = 1'b0;
  endtask

  task automatic doCapture(input logic [2*HW-1:0] exp, input bit req, input string tag);
    @(negedge clk) begin capEvent = 1'b1; rdReq = req; end
    chk(rdWait == 1'b0, "R5", {tag, " wait idle"}, rdWait, 0);
    @(negedge clk) capEvent = 1'b0;
    chk(rdEnable == 1'b0, "R6", {tag, " rdEnable low"}, rdEnable, 0);
    chk(rdWait == req, "R5", {tag, " wait phase1"}, rdWait, req);
    @(negedge clk);
    chk(subCap == exp[HW-1:0], tag, "subCap", subCap, exp[HW-1:0]);
    chk(rdWait == req, "R5", {tag, " wait phase2"}, rdWait, req);
    @(negedge clk);
    chk(mainCap == exp[2*HW-1:HW], tag, "mainCap", mainCap, exp[2*HW-1:HW]);
    chk(rdEnable == 1'b1, "R6", {tag, " rdEnable back"}, rdEnable, 1);
    chk(rdWait == 1'b0, "R5", {tag, " wait released"}, rdWait, 0);
    rdReq = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    chk(subCap == 0 && mainCap == 0, "R8", "regs in reset", {subCap, mainCap}, 0);
    chk(rdEnable == 1 && rdWait == 0, "R8", "flags in reset", {rdEnable, rdWait}, 2);
    rst_n = 1'b1;

    // R3 / R2: table of step counts and expected snapshots
    for (int i = 0; i < VEC_N; i++) begin
      repeat (STEPS_TAB[i]) stepOnce();
      doCapture(EXP_TAB[i], 1'b0, "R3_R2 table");
    end

    // R1: holding the strobe high gives a single step
    @(negedge clk) cntEnable = 1'b1;
    repeat (6) @(negedge clk);
    cntEnable = 1'b0;
    doCapture(16'h0208, 1'b0, "R1 held high");

    // R4: event during phase 2 is dropped; a step in phase 2 applies normally
    @(negedge clk) capEvent = 1'b1;
    @(negedge clk) capEvent = 1'b0;
    @(negedge clk) begin capEvent = 1'b1; cntEnable = 1'b1; end
    @(negedge clk) begin capEvent = 1'b0; cntEnable = 1'b0; end
    chk(subCap == 8'h08 && mainCap == 8'h02, "R4", "first capture", {mainCap, subCap}, 16'h0208);
    repeat (3) @(negedge clk);
    chk(subCap == 8'h08, "R4", "no second capture", subCap, 8'h08);
    chk(rdEnable == 1'b1, "R4", "stays idle", rdEnable, 1);
    doCapture(16'h0209, 1'b0, "R4 step kept");

    // R7: step edge in phase 1 right at rollover is deferred
    repeat (8'hF6) stepOnce();
    @(negedge clk) capEvent = 1'b1;
    @(negedge clk) begin capEvent = 1'b0; cntEnable = 1'b1; end
    @(negedge clk);
    chk(subCap == 8'hFF, "R7", "sub before step", subCap, 8'hFF);
    @(negedge clk) cntEnable = 1'b0;
    chk(mainCap == 8'h02, "R7", "main coherent", mainCap, 8'h02);
    doCapture(16'h0300, 1'b1, "R7_R5 step not lost");

    // R8: reset in mid-run clears everything
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    chk(subCap == 0 && mainCap == 0, "R8", "regs after reset", {mainCap, subCap}, 0);
    @(negedge clk) rst_n = 1'b1;
    doCapture(16'h0000, 1'b0, "R8 counter cleared");

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule